// File: doc/BRIEF.md
# Bus Transaction Latency Monitor

This block watches the handshake signals of one AXI manager-to-subordinate link and times each transaction in clock cycles. It times three things: from read address acceptance to the first accepted read beat, from read address acceptance to the accepted beat marked last, and from write address acceptance to the accepted write response. All of its bus-side pins are inputs, so it has no way to affect the link it observes.

Each metric has its own statistics: a sample count, a running sum, the smallest and largest latency seen, and a sixteen-bin histogram. The largest value shows the worst case under contention, and the histogram shows the spread. A separate counter records read bursts whose beats did not stream back to back. Transactions are paired with their responses in issue order, one queue per direction. Because IDs are not examined, the monitor is only meaningful on a link that returns responses in order.

Software takes a snapshot to freeze a copy of every statistic, then reads the copy word by word through a small read port. Values read after one snapshot belong together even while live traffic continues.

Top module: `axi_lat_monitor`

## Requirements
- R1: The first-word read latency of a transaction is the number of clock edges from the edge on which arValid and arReady are both high to the edge on which the first rValid/rReady beat of that burst is accepted.
- R2: The last-word read latency is measured from the same address edge to the edge accepting the beat with rLast high. For a single-beat burst it equals the first-word latency.
- R3: The write latency is the number of edges from the awValid/awReady edge to the bValid/bReady edge.
- R4: Up to 16 reads and 16 writes may be outstanding. Responses are matched to addresses oldest first.
- R5: The stall counter (read word 96) increments once for each read burst whose last-beat time minus first-beat time is greater than arLen (arLen = beats minus one). A burst that streams without gaps does not increment it.
- R6: Each metric keeps a 32-bit count, a 48-bit sum, a minimum that resets to all ones and a maximum that resets to zero. Word offsets within a metric are: 0 count, 1 sum bits 31:0, 2 sum bits 47:32, 3 minimum, 4 maximum.
- R7: Histogram bin k (word offset 16+k) counts latencies in the range 8k to 8k+7 for k below 15. Bin 15 counts every latency of 120 or more. Bin counters saturate at all ones.
- R8: An address accepted while its direction's queue holds 16 entries and no entry leaves in that cycle is dropped. It sets a sticky flag: bit 0 of word 97 for reads, bit 1 for writes.
- R9: A one-cycle statClear pulse returns every count, sum, minimum, maximum, bin, the stall counter and both overflow flags to their reset values.
- R10: Reads return the values captured by the most recent statSnap pulse. rdData and rdValid appear one cycle after rdEn. Metric bases are 0 first-word, 32 last-word, 64 write, and 96 for the status words.
- R11: A read beat or write response accepted while its direction has nothing outstanding changes no statistic and does not disturb later matching.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock of the observed link |
| rstN | input | 1 | Active-low synchronous reset |
| arValid | input | 1 | Observed read address valid |
| arReady | input | 1 | Observed read address ready |
| arLen | input | 8 | Observed read burst length minus one |
| rValid | input | 1 | Observed read data valid |
| rReady | input | 1 | Observed read data ready |
| rLast | input | 1 | Observed last read beat marker |
| awValid | input | 1 | Observed write address valid |
| awReady | input | 1 | Observed write address ready |
| bValid | input | 1 | Observed write response valid |
| bReady | input | 1 | Observed write response ready |
| statClear | input | 1 | Clears all statistics and flags |
| statSnap | input | 1 | Captures the live statistics into the read copy |
| rdEn | input | 1 | Read request for the statistics port |
| rdAddr | input | 7 | Word address of the statistics port |
| rdData | output | 32 | Word read from the captured copy |
| rdValid | output | 1 | rdData is valid this cycle |

## Verification
The hardest states to reach are a full timestamp queue and several overlapping reads with different latencies, because the bus side only sees handshakes. To fill the queue, the stimulus issues seventeen read addresses back to back with no data returned. For the ordering check, it overlaps two addresses and returns their single beats at deliberately unequal distances, so that any wrong pairing would show up as a different sum, minimum or maximum. Histogram edges are reached with single-beat reads timed to land exactly on 7, 8, 119 and 120 cycles, plus one well beyond the last bin.

// File: rtl/lat_mon_pkg.sv
package lat_mon_pkg;
  localparam int TS_W        = 32;
  localparam int CNT_W       = 32;
  localparam int SUM_W       = 48;
  localparam int LEN_W       = 8;
  localparam int NUM_BINS    = 16;
  localparam int BIN_SHIFT   = 3;
  localparam int FIFO_DEPTH  = 16;
  localparam int NUM_METRICS = 3;
  localparam int DATA_W      = 32;
  localparam int WSEL_W      = $clog2(2 * NUM_BINS);
  localparam int ADDR_W      = 2 + WSEL_W;

  // Per-cycle events from the control side to the statistics side
  typedef struct packed {
    logic            rdFirst;
    logic            rdLast;
    logic            wrDone;
    logic            stall;
    logic            rdOvf;
    logic            wrOvf;
    logic [TS_W-1:0] rdFirstLat;
    logic [TS_W-1:0] rdLastLat;
    logic [TS_W-1:0] wrLat;
  } monStrobes_t;
endpackage

// File: rtl/lat_mon_fifo.sv
module lat_mon_fifo #(
  parameter int WIDTH = 40,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wData,
  output logic [WIDTH-1:0] head,
  output logic             full,
  output logic             empty
);
  localparam int PW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW:0]      wPtr;
  logic [PW:0]      rPtr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wPtr <= '0;
      rPtr <= '0;
    end else begin
      if (push) wPtr <= wPtr + 1'b1;
      if (pop)  rPtr <= rPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wPtr[PW-1:0]] <= wData;
  end

  assign head  = mem[rPtr[PW-1:0]];
  assign empty = (wPtr == rPtr);
  assign full  = (wPtr[PW-1:0] == rPtr[PW-1:0]) && (wPtr[PW] != rPtr[PW]);

  // R4: the control never retires an entry that is not there
  p_no_pop_empty_r4: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> !empty);
  // R8: an entry is never written over while the queue is full
  p_no_push_full_r8: assert property (@(posedge clk) disable iff (!rstN)
    (push && !pop) |-> !full);
endmodule

// File: rtl/lat_mon_ctrl.sv
module lat_mon_ctrl
  import lat_mon_pkg::*;
#(
  parameter int DEPTH = FIFO_DEPTH
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             arValid,
  input  logic             arReady,
  input  logic [LEN_W-1:0] arLen,
  input  logic             rValid,
  input  logic             rReady,
  input  logic             rLast,
  input  logic             awValid,
  input  logic             awReady,
  input  logic             bValid,
  input  logic             bReady,
  output monStrobes_t      strobes
);
  localparam int RD_W = LEN_W + TS_W;

  logic [TS_W-1:0] cycNow;
  logic [TS_W-1:0] firstTs;
  logic            inBurst;

  logic            arFire, rFire, awFire, bFire;
  logic            rEvt, bEvt;
  logic            rdPush, rdPop, wrPush, wrPop;
  logic [RD_W-1:0] rdHead;
  logic            rdFull, rdEmpty;
  logic [TS_W-1:0] wrHead;
  logic            wrFull, wrEmpty;
  logic [TS_W-1:0] headTs;
  logic [LEN_W-1:0] headLen;
  logic [TS_W-1:0] burstGap;

  assign arFire = arValid && arReady;
  assign rFire  = rValid && rReady;
  assign awFire = awValid && awReady;
  assign bFire  = bValid && bReady;

  assign rEvt   = rFire && !rdEmpty;
  assign bEvt   = bFire && !wrEmpty;
  assign rdPop  = rEvt && rLast;
  assign wrPop  = bEvt;
  assign rdPush = arFire && (!rdFull || rdPop);
  assign wrPush = awFire && (!wrFull || wrPop);

  assign headTs   = rdHead[TS_W-1:0];
  assign headLen  = rdHead[RD_W-1:TS_W];
  assign burstGap = inBurst ? (cycNow - firstTs) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cycNow  <= '0;
      inBurst <= 1'b0;
      firstTs <= '0;
    end else begin
      cycNow <= cycNow + 1'b1;
      if (rEvt) begin
        inBurst <= !rLast;
        if (!inBurst) firstTs <= cycNow;
      end
    end
  end

  lat_mon_fifo #(.WIDTH(RD_W), .DEPTH(DEPTH)) uRdQ (
    .clk(clk), .rstN(rstN), .push(rdPush), .pop(rdPop),
    .wData({arLen, cycNow}), .head(rdHead), .full(rdFull), .empty(rdEmpty)
  );

  lat_mon_fifo #(.WIDTH(TS_W), .DEPTH(DEPTH)) uWrQ (
    .clk(clk), .rstN(rstN), .push(wrPush), .pop(wrPop),
    .wData(cycNow), .head(wrHead), .full(wrFull), .empty(wrEmpty)
  );

  always_comb begin
    strobes            = '0;
    strobes.rdFirst    = rEvt && !inBurst;
    strobes.rdLast     = rdPop;
    strobes.wrDone     = wrPop;
    strobes.stall      = rdPop && (burstGap > TS_W'(headLen));
    strobes.rdOvf      = arFire && !rdPush;
    strobes.wrOvf      = awFire && !wrPush;
    strobes.rdFirstLat = cycNow - headTs;
    strobes.rdLastLat  = cycNow - headTs;
    strobes.wrLat      = cycNow - wrHead;
  end

  // R5: a streaming gap only exists for bursts of more than one beat
  p_stall_multi_beat_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.stall |-> (strobes.rdLast && !strobes.rdFirst));
  // R11: an unmatched response never produces a sample
  p_stray_ignored_r11: assert property (@(posedge clk) disable iff (!rstN)
    (rFire && rdEmpty) |-> !(strobes.rdFirst || strobes.rdLast));
endmodule

// File: rtl/lat_mon_stats.sv
module lat_mon_stats #(
  parameter int TS_W      = 32,
  parameter int CNT_W     = 32,
  parameter int SUM_W     = 48,
  parameter int NUM_BINS  = 16,
  parameter int BIN_SHIFT = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clear,
  input  logic             sample,
  input  logic [TS_W-1:0]  lat,
  output logic [CNT_W-1:0] cnt,
  output logic [SUM_W-1:0] sum,
  output logic [TS_W-1:0]  minLat,
  output logic [TS_W-1:0]  maxLat,
  output logic [CNT_W-1:0] binCnt [NUM_BINS]
);
  localparam int BIN_IDX_W = $clog2(NUM_BINS);
  localparam logic [TS_W-1:0] LAST_BIN_LO = TS_W'((NUM_BINS - 1) << BIN_SHIFT);

  logic [BIN_IDX_W-1:0] binIdx;

  always_comb begin
    if (lat >= LAST_BIN_LO) binIdx = BIN_IDX_W'(NUM_BINS - 1);
    else                    binIdx = BIN_IDX_W'(lat >> BIN_SHIFT);
  end

  always_ff @(posedge clk) begin
    if (!rstN || clear) begin
      cnt    <= '0;
      sum    <= '0;
      minLat <= '1;
      maxLat <= '0;
    end else if (sample) begin
      cnt <= cnt + 1'b1;
      sum <= sum + SUM_W'(lat);
      if (lat < minLat) minLat <= lat;
      if (lat > maxLat) maxLat <= lat;
    end
  end

  for (genvar b = 0; b < NUM_BINS; b++) begin : g_bin
    always_ff @(posedge clk) begin
      if (!rstN || clear) binCnt[b] <= '0;
      else if (sample && binIdx == BIN_IDX_W'(b) && binCnt[b] != '1)
        binCnt[b] <= binCnt[b] + 1'b1;
    end
  end

  // R6: each accepted sample advances the count by exactly one
  p_count_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (sample && !clear) |=> cnt == $past(cnt) + 1'b1);
  // R6: once samples exist the extremes stay ordered
  p_min_le_max_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cnt != '0) |-> (minLat <= maxLat));
  // R7: the tail bin holds at its ceiling
  p_bin_sat_r7: assert property (@(posedge clk) disable iff (!rstN)
    (binCnt[NUM_BINS-1] == '1 && !clear) |=> binCnt[NUM_BINS-1] == '1);
endmodule

// File: rtl/lat_mon_dpath.sv
module lat_mon_dpath
  import lat_mon_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  monStrobes_t       strobes,
  input  logic              statClear,
  input  logic              statSnap,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  logic             sampleVec [NUM_METRICS];
  logic [TS_W-1:0]  latVec    [NUM_METRICS];

  logic [CNT_W-1:0] cntLive [NUM_METRICS];
  logic [SUM_W-1:0] sumLive [NUM_METRICS];
  logic [TS_W-1:0]  minLive [NUM_METRICS];
  logic [TS_W-1:0]  maxLive [NUM_METRICS];
  logic [CNT_W-1:0] binLive [NUM_METRICS][NUM_BINS];

  logic [CNT_W-1:0] cntSnap [NUM_METRICS];
  logic [SUM_W-1:0] sumSnap [NUM_METRICS];
  logic [TS_W-1:0]  minSnap [NUM_METRICS];
  logic [TS_W-1:0]  maxSnap [NUM_METRICS];
  logic [CNT_W-1:0] binSnap [NUM_METRICS][NUM_BINS];

  logic [CNT_W-1:0] stallLive, stallSnap;
  logic             rdOvfLive, wrOvfLive, rdOvfSnap, wrOvfSnap;

  logic [1:0]        metSel;
  logic [WSEL_W-1:0] wordSel;
  logic [DATA_W-1:0] word;

  always_comb begin
    sampleVec[0] = strobes.rdFirst;
    sampleVec[1] = strobes.rdLast;
    sampleVec[2] = strobes.wrDone;
    latVec[0]    = strobes.rdFirstLat;
    latVec[1]    = strobes.rdLastLat;
    latVec[2]    = strobes.wrLat;
  end

  for (genvar g = 0; g < NUM_METRICS; g++) begin : g_metric
    lat_mon_stats #(
      .TS_W(TS_W), .CNT_W(CNT_W), .SUM_W(SUM_W),
      .NUM_BINS(NUM_BINS), .BIN_SHIFT(BIN_SHIFT)
    ) uStats (
      .clk(clk), .rstN(rstN), .clear(statClear),
      .sample(sampleVec[g]), .lat(latVec[g]),
      .cnt(cntLive[g]), .sum(sumLive[g]),
      .minLat(minLive[g]), .maxLat(maxLive[g]),
      .binCnt(binLive[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN || statClear) begin
      stallLive <= '0;
      rdOvfLive <= 1'b0;
      wrOvfLive <= 1'b0;
    end else begin
      if (strobes.stall) stallLive <= stallLive + 1'b1;
      if (strobes.rdOvf) rdOvfLive <= 1'b1;
      if (strobes.wrOvf) wrOvfLive <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int m = 0; m < NUM_METRICS; m++) begin
        cntSnap[m] <= '0;
        sumSnap[m] <= '0;
        minSnap[m] <= '1;
        maxSnap[m] <= '0;
        for (int b = 0; b < NUM_BINS; b++) binSnap[m][b] <= '0;
      end
      stallSnap <= '0;
      rdOvfSnap <= 1'b0;
      wrOvfSnap <= 1'b0;
    end else if (statSnap) begin
      for (int m = 0; m < NUM_METRICS; m++) begin
        cntSnap[m] <= cntLive[m];
        sumSnap[m] <= sumLive[m];
        minSnap[m] <= minLive[m];
        maxSnap[m] <= maxLive[m];
        for (int b = 0; b < NUM_BINS; b++) binSnap[m][b] <= binLive[m][b];
      end
      stallSnap <= stallLive;
      rdOvfSnap <= rdOvfLive;
      wrOvfSnap <= wrOvfLive;
    end
  end

  assign metSel  = rdAddr[ADDR_W-1 -: 2];
  assign wordSel = rdAddr[WSEL_W-1:0];

  always_comb begin
    word = '0;
    if (metSel == 2'd3) begin
      if (int'(wordSel) == 0)      word = DATA_W'(stallSnap);
      else if (int'(wordSel) == 1) word = DATA_W'({wrOvfSnap, rdOvfSnap});
    end else if (wordSel[WSEL_W-1]) begin
      word = DATA_W'(binSnap[metSel][wordSel[WSEL_W-2:0]]);
    end else begin
      case (int'(wordSel[WSEL_W-2:0]))
        0:       word = DATA_W'(cntSnap[metSel]);
        1:       word = DATA_W'(sumSnap[metSel]);
        2:       word = DATA_W'(sumSnap[metSel] >> DATA_W);
        3:       word = DATA_W'(minSnap[metSel]);
        4:       word = DATA_W'(maxSnap[metSel]);
        default: word = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= rdEn;
      if (rdEn) rdData <= word;
    end
  end

  // R8: an overflow flag stays set until cleared
  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rdOvfLive && !statClear) |=> rdOvfLive);
  // R10: read data follows a request by one cycle, and only then
  p_rd_latency_r10: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rdValid);
  p_rd_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> !rdValid);
  // R10: the captured copy moves only on a snapshot
  p_snap_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !statSnap |=> $stable(cntSnap[0]));
  // R2: single-beat bursts give equal first and last latencies
  p_single_beat_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdFirst && strobes.rdLast) |-> strobes.rdFirstLat == strobes.rdLastLat);
endmodule

// File: rtl/axi_lat_monitor.sv
module axi_lat_monitor
  import lat_mon_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              arValid,
  input  logic              arReady,
  input  logic [LEN_W-1:0]  arLen,
  input  logic              rValid,
  input  logic              rReady,
  input  logic              rLast,
  input  logic              awValid,
  input  logic              awReady,
  input  logic              bValid,
  input  logic              bReady,
  input  logic              statClear,
  input  logic              statSnap,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  monStrobes_t strobes;

  lat_mon_ctrl #(.DEPTH(FIFO_DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN),
    .arValid(arValid), .arReady(arReady), .arLen(arLen),
    .rValid(rValid), .rReady(rReady), .rLast(rLast),
    .awValid(awValid), .awReady(awReady),
    .bValid(bValid), .bReady(bReady),
    .strobes(strobes)
  );

  lat_mon_dpath uDpath (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .statClear(statClear), .statSnap(statSnap),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .rdValid(rdValid)
  );
endmodule

// File: tb/tb_axi_lat_monitor.sv
`timescale 1ns/1ps
module tb_axi_lat_monitor;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        arValid = 0, arReady = 0, rValid = 0, rReady = 0, rLast = 0;
  logic        awValid = 0, awReady = 0, bValid = 0, bReady = 0;
  logic [7:0]  arLen = '0;
  logic        statClear = 0, statSnap = 0, rdEn = 0;
  logic [6:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic        rdValid;

  int  testsRun = 0;
  int  testsFailed = 0;
  bit  done = 0;

  localparam int FIRST = 0, LAST = 32, WR = 64, STAT = 96;

  always #2.5 clk = ~clk;

  axi_lat_monitor dut (
    .clk(clk), .rstN(rstN),
    .arValid(arValid), .arReady(arReady), .arLen(arLen),
    .rValid(rValid), .rReady(rReady), .rLast(rLast),
    .awValid(awValid), .awReady(awReady),
    .bValid(bValid), .bReady(bReady),
    .statClear(statClear), .statSnap(statSnap),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .rdValid(rdValid)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pulseClear();
    @(negedge clk); statClear = 1;
    @(negedge clk); statClear = 0;
  endtask

  task automatic pulseSnap();
    @(negedge clk); statSnap = 1;
    @(negedge clk); statSnap = 0;
  endtask

  task automatic readWord(input int addr, output logic [31:0] val);
    @(negedge clk); rdEn = 1; rdAddr = 7'(addr);
    @(negedge clk); rdEn = 0;
    val = rdData;
  endtask

  task automatic expectWord(input string req, input string what,
                            input int addr, input logic [31:0] exp);
    logic [31:0] v;
    readWord(addr, v);
    check(req, what, v, exp);
  endtask

  task automatic issueAr(input int len);
    @(negedge clk); arValid = 1; arReady = 1; arLen = 8'(len);
    @(negedge clk); arValid = 0; arReady = 0;
  endtask

  // first beat lands 'delay' edges after the address edge; one idle cycle before beat stallAt
  task automatic readTxn(input int len, input int delay, input int stallAt);
    issueAr(len);
    repeat (delay - 1) @(negedge clk);
    for (int i = 0; i <= len; i++) begin
      if (i == stallAt && i > 0) begin
        rValid = 0; rLast = 0;
        @(negedge clk);
      end
      rValid = 1; rReady = 1; rLast = (i == len);
      @(negedge clk);
    end
    rValid = 0; rReady = 0; rLast = 0;
  endtask

  task automatic writeTxn(input int delay);
    @(negedge clk); awValid = 1; awReady = 1;
    @(negedge clk); awValid = 0; awReady = 0;
    repeat (delay - 1) @(negedge clk);
    bValid = 1; bReady = 1;
    @(negedge clk); bValid = 0; bReady = 0;
  endtask

  task automatic testReset();
    pulseSnap();
    expectWord("R6", "reset count", FIRST + 0, 0);
    expectWord("R6", "reset min", FIRST + 3, 32'hFFFF_FFFF);
    expectWord("R6", "reset max", WR + 4, 0);
    expectWord("R8", "reset flags", STAT + 1, 0);
  endtask

  task automatic testBurst();
    pulseClear();
    readTxn(3, 4, -1);
    pulseSnap();
    expectWord("R1", "first-word latency", FIRST + 4, 4);
    expectWord("R2", "last-word latency", LAST + 4, 7);
    expectWord("R5", "no stall on streaming burst", STAT + 0, 0);
  endtask

  task automatic testSingleBeat();
    pulseClear();
    readTxn(0, 5, -1);
    pulseSnap();
    expectWord("R2", "single beat last", LAST + 4, 5);
    expectWord("R1", "single beat first", FIRST + 3, 5);
  endtask

  task automatic testStall();
    pulseClear();
    readTxn(3, 2, 2);
    readTxn(3, 4, -1);
    pulseSnap();
    expectWord("R5", "stall count", STAT + 0, 1);
    expectWord("R2", "stalled burst last-word min", LAST + 3, 6);
    expectWord("R1", "first-word max", FIRST + 4, 4);
  endtask

  task automatic testWrite();
    pulseClear();
    writeTxn(9);
    pulseSnap();
    expectWord("R3", "write latency", WR + 4, 9);
    expectWord("R3", "write count", WR + 0, 1);
    expectWord("R3", "reads untouched", FIRST + 0, 0);
  endtask

  task automatic testOrder();
    pulseClear();
    @(negedge clk); arValid = 1; arReady = 1; arLen = 0;
    @(negedge clk);
    @(negedge clk); arValid = 0; arReady = 0;
    @(negedge clk); rValid = 1; rReady = 1; rLast = 1;
    @(negedge clk); rValid = 0; rReady = 0; rLast = 0;
    repeat (6) @(negedge clk);
    rValid = 1; rReady = 1; rLast = 1;
    @(negedge clk); rValid = 0; rReady = 0; rLast = 0;
    pulseSnap();
    expectWord("R4", "count", FIRST + 0, 2);
    expectWord("R4", "sum", FIRST + 1, 12);
    expectWord("R4", "min", FIRST + 3, 3);
    expectWord("R4", "max", LAST + 4, 9);
  endtask

  task automatic testStats();
    pulseClear();
    writeTxn(3);
    writeTxn(12);
    writeTxn(6);
    pulseSnap();
    expectWord("R6", "count", WR + 0, 3);
    expectWord("R6", "sum low", WR + 1, 21);
    expectWord("R6", "sum high", WR + 2, 0);
    expectWord("R6", "min", WR + 3, 3);
    expectWord("R6", "max", WR + 4, 12);
  endtask

  task automatic testHist();
    pulseClear();
    readTxn(0, 7, -1);
    readTxn(0, 8, -1);
    readTxn(0, 119, -1);
    readTxn(0, 120, -1);
    readTxn(0, 200, -1);
    pulseSnap();
    expectWord("R7", "bin 0", FIRST + 16, 1);
    expectWord("R7", "bin 1", FIRST + 17, 1);
    expectWord("R7", "bin 2", FIRST + 18, 0);
    expectWord("R7", "bin 14", FIRST + 30, 1);
    expectWord("R7", "bin 15", FIRST + 31, 2);
  endtask

  task automatic testStray();
    pulseClear();
    @(negedge clk); rValid = 1; rReady = 1; rLast = 1;
    @(negedge clk); rValid = 0; rReady = 0; rLast = 0;
    bValid = 1; bReady = 1;
    @(negedge clk); bValid = 0; bReady = 0;
    pulseSnap();
    expectWord("R11", "stray beat first count", FIRST + 0, 0);
    expectWord("R11", "stray beat last count", LAST + 0, 0);
    expectWord("R11", "stray response count", WR + 0, 0);
    readTxn(0, 5, -1);
    pulseSnap();
    expectWord("R11", "later read still timed", FIRST + 4, 5);
  endtask

  task automatic testSnapshot();
    logic [31:0] v;
    pulseClear();
    readTxn(0, 3, -1);
    pulseSnap();
    readTxn(0, 4, -1);
    expectWord("R10", "frozen count", FIRST + 0, 1);
    pulseSnap();
    @(negedge clk); rdEn = 1; rdAddr = 7'(FIRST + 0);
    check("R10", "no valid before edge", {31'b0, rdValid}, 0);
    @(negedge clk); rdEn = 0;
    check("R10", "valid one cycle later", {31'b0, rdValid}, 1);
    v = rdData;
    check("R10", "new count", v, 2);
    @(negedge clk);
    check("R10", "valid drops", {31'b0, rdValid}, 0);
  endtask

  task automatic testOverflow();
    pulseClear();
    for (int i = 0; i < 17; i++) issueAr(0);
    pulseSnap();
    expectWord("R8", "read overflow flag", STAT + 1, 1);
    pulseSnap();
    expectWord("R8", "flag sticky", STAT + 1, 1);
  endtask

  task automatic testClear();
    writeTxn(4);
    pulseClear();
    pulseSnap();
    expectWord("R9", "flags cleared", STAT + 1, 0);
    expectWord("R9", "count cleared", WR + 0, 0);
    expectWord("R9", "min reset", WR + 3, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1;
    testReset();
    testBurst();
    testSingleBeat();
    testStall();
    testWrite();
    testOrder();
    testStats();
    testHist();
    testStray();
    testSnapshot();
    testOverflow();
    testClear();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule